// File: doc/BRIEF.md
# I2C Register-Write Master with CRC-8 Trailer

This block is a synchronous I2C controller that always acts as bus master and is the only source of SCL. It performs one register write per request to a target that expects an integrity byte at the end of every write. The host presents a 7-bit target address, an 8-bit register index and an 8-bit value, then pulses `start_i`.

The controller first runs a bit-serial CRC-8 over the three payload bytes. It then sends START, the address byte (address shifted left with a 0 write bit), the register byte, the data byte, the CRC byte and STOP. After every byte it checks for an acknowledge. If any byte is refused, it issues STOP at once and reports which byte failed. Both bus lines are open-drain and appear as drive-low enables. SDA is also read back from the bus.

Top module: `i2c_crc_writer`

## Requirements
- R1: After reset, and whenever `busy_o` is low, neither `scl_drive_o` nor `sda_drive_o` pulls its line low. Also `done_o` is 0 and `nack_err_o` is 0 after reset.
- R2: A write puts these on the bus in order: START, byte 0 = `{tgt_addr_i, 1'b0}`, byte 1 = `reg_addr_i`, byte 2 = `data_i`, byte 3 = CRC, then STOP. Each byte is sent MSB first.
- R3: The CRC uses polynomial 0x07 (x^8+x^2+x+1) and starts from 0x00, with no reflection and no final XOR. It is the remainder of the 24 payload bits followed by eight zero bits, bytes taken in address, register, data order. With `CRC_ADDR_SHIFTED`=1 the address byte fed in is `{addr,0}`; with 0 it is `{0,addr}`.
- R4: The acknowledge is taken in the 9th SCL high phase of each byte, with the master's SDA released. SDA low means accepted; SDA high means refused.
- R5: When a byte is refused, the controller sends no further bytes and issues STOP. It sets `nack_err_o`=1 and `nack_idx_o` to the byte index (0 address, 1 register, 2 data, 3 CRC).
- R6: While SCL is released within a byte, SDA does not change. The only SDA transitions during SCL high are the one START (falling) and the one STOP (rising) of a write.
- R7: `done_o` is a one-cycle pulse at the end of every write, successful or not, and `busy_o` is low in that cycle. `start_i` is ignored while `busy_o` is high.
- R8: Every SCL high phase of a byte lasts exactly 2*`CLK_DIV` clock cycles, and every SCL low phase lasts 2*`CLK_DIV` clock cycles.
- R9: An accepted `start_i` clears `nack_err_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a write; accepted only when idle |
| tgt_addr_i | input | 7 | Target address |
| reg_addr_i | input | 8 | Register index in the target |
| data_i | input | 8 | Value to write |
| busy_o | output | 1 | Write in progress |
| done_o | output | 1 | One-cycle end-of-write pulse |
| nack_err_o | output | 1 | Last write was refused |
| nack_idx_o | output | 2 | Index of the refused byte |
| scl_drive_o | output | 1 | Pull SCL low when 1 |
| sda_drive_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA bus level |

## Verification
The bench builds two instances with `CLK_DIV`=2: one with `CRC_ADDR_SHIFTED`=1 and one with `CRC_ADDR_SHIFTED`=0. Both run on separate bus models with identical requests, so both address conventions of the CRC are compared on every write. The small divider lets a sweep of all 256 data values reach the bench within budget, each with varied addresses and register indices. The sweep is followed by a forced refusal at each of the four byte positions, a write that clears the error, and a start pulse issued mid-frame.

// File: rtl/i2c_crc_pkg.sv
package i2c_crc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CRC,
    ST_START,
    ST_BIT,
    ST_STOP
  } wr_state_e;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PAY_W   = 3 * BYTE_W;
  localparam logic [7:0]  CRC_POLY = 8'h07;
endpackage

// File: rtl/i2c_crc_tick.sv
module i2c_crc_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/i2c_crc_crc8.sv
module i2c_crc_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [7:0] crc_o
);
  logic [7:0] crc_q;
  logic       fb;

  assign fb = crc_q[7] ^ bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= {crc_q[6:0], 1'b0} ^ (fb ? POLY : 8'h00);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/i2c_crc_writer.sv
module i2c_crc_writer
  import i2c_crc_pkg::*;
#(
  parameter int unsigned CLK_DIV          = 4,
  parameter bit          CRC_ADDR_SHIFTED = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [6:0] tgt_addr_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       nack_err_o,
  output logic [1:0] nack_idx_o,
  output logic       scl_drive_o,
  output logic       sda_drive_o,
  input  logic       sda_i
);
  localparam int unsigned CCW = $clog2(PAY_W);
  localparam logic [CCW-1:0] CRC_LAST = CCW'(PAY_W - 1);

  wr_state_e         st_q;
  logic [1:0]        q_q;
  logic [3:0]        bit_q;
  logic [1:0]        byte_q;
  logic [2:0][7:0]   frame_q;
  logic [7:0]        tx_q;
  logic [PAY_W-1:0]  msg_q;
  logic [CCW-1:0]    ccnt_q;
  logic              sda_q, done_q, nerr_q;
  logic [1:0]        nidx_q;

  logic              tick, accept;
  logic [7:0]        crc, crc_addr, next_byte;
  logic              in_bit;

  assign accept = (st_q == ST_IDLE) && start_i;
  assign in_bit = (st_q == ST_BIT);

  generate
    if (CRC_ADDR_SHIFTED) begin : g_addr_wire
      assign crc_addr = {tgt_addr_i, 1'b0};
    end else begin : g_addr_raw
      assign crc_addr = {1'b0, tgt_addr_i};
    end
  endgenerate

  i2c_crc_tick #(.DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (st_q == ST_START || st_q == ST_BIT || st_q == ST_STOP),
    .tick_o(tick)
  );

  i2c_crc_crc8 #(.POLY(CRC_POLY)) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .en_i  (st_q == ST_CRC),
    .bit_i (msg_q[PAY_W-1]),
    .crc_o (crc)
  );

  always_comb begin
    case (byte_q)
      2'd0:    next_byte = frame_q[1];
      2'd1:    next_byte = frame_q[2];
      default: next_byte = crc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      q_q     <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      frame_q <= '0;
      tx_q    <= '0;
      msg_q   <= '0;
      ccnt_q  <= '0;
      sda_q   <= 1'b0;
      done_q  <= 1'b0;
      nerr_q  <= 1'b0;
      nidx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          frame_q <= {data_i, reg_addr_i, {tgt_addr_i, 1'b0}};
          msg_q   <= {crc_addr, reg_addr_i, data_i};
          ccnt_q  <= '0;
          nerr_q  <= 1'b0;
          nidx_q  <= '0;
          st_q    <= ST_CRC;
        end
        ST_CRC: begin
          msg_q  <= {msg_q[PAY_W-2:0], 1'b0};
          ccnt_q <= ccnt_q + 1'b1;
          if (ccnt_q == CRC_LAST) begin
            st_q <= ST_START;
            q_q  <= '0;
          end
        end
        ST_START: if (tick) begin
          q_q <= q_q + 1'b1;
          if (q_q == 2'd0) sda_q <= 1'b1;  // START: SDA falls, SCL high
          if (q_q == 2'd1) begin
            st_q   <= ST_BIT;
            q_q    <= '0;
            bit_q  <= '0;
            byte_q <= '0;
            tx_q   <= frame_q[0];
          end
        end
        ST_BIT: if (tick) begin
          q_q <= q_q + 1'b1;
          // SDA updated after a full quarter of SCL low
          if (q_q == 2'd0) sda_q <= (bit_q == 4'd8) ? 1'b0 : ~tx_q[7];
          if (q_q == 2'd3) begin
            if (bit_q != 4'd8) begin
              tx_q  <= {tx_q[6:0], 1'b0};
              bit_q <= bit_q + 1'b1;
            end else if (sda_i) begin
              nerr_q <= 1'b1;
              nidx_q <= byte_q;
              st_q   <= ST_STOP;
            end else if (byte_q == 2'd3) begin
              st_q <= ST_STOP;
            end else begin
              byte_q <= byte_q + 1'b1;
              bit_q  <= '0;
              tx_q   <= next_byte;
            end
          end
        end
        ST_STOP: if (tick) begin
          q_q <= q_q + 1'b1;
          if (q_q == 2'd0) sda_q <= 1'b1;
          if (q_q == 2'd2) sda_q <= 1'b0;  // STOP: SDA rises, SCL high
          if (q_q == 2'd3) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign nack_err_o  = nerr_q;
  assign nack_idx_o  = nidx_q;
  assign sda_drive_o = sda_q;
  assign scl_drive_o = (st_q == ST_BIT || st_q == ST_STOP) && !q_q[1];
endmodule

// File: rtl/i2c_crc_writer_chk.sv
module i2c_crc_writer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic nack_err_o,
  input logic scl_drive_o,
  input logic sda_drive_o,
  input logic in_bit_i
);
  // R1
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_drive_o && !sda_drive_o));

  // R6
  a_r6_sda_stable_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_bit_i && $past(in_bit_i) && !scl_drive_o && $past(!scl_drive_o))
      |-> $stable(sda_drive_o));

  // R7
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R5
  a_r5_nack_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nack_err_o) |-> (busy_o && scl_drive_o));

  // R9
  a_r9_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !nack_err_o));
endmodule

bind i2c_crc_writer i2c_crc_writer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .nack_err_o (nack_err_o),
  .scl_drive_o(scl_drive_o),
  .sda_drive_o(sda_drive_o),
  .in_bit_i   (in_bit)
);

// File: tb/i2c_crc_writer_bench.sv
module i2c_crc_tgt (
  input  logic            clk,
  input  logic            clr,
  input  logic            scl,
  input  logic            sda,
  input  logic [2:0]      nack_at,
  input  int              hi_exp,
  output logic            pull,
  output logic [3:0][7:0] rx,
  output int              nb,
  output int              starts,
  output int              stops,
  output int              bad_w
);
  logic       scl_p, sda_p, in_frame, ackph, seen_rise;
  logic [3:0] bitc;
  logic [7:0] sh;
  int         hi_cnt;

  always @(posedge clk) begin
    if (clr) begin
      pull <= 0; rx <= '0; nb <= 0; starts <= 0; stops <= 0; bad_w <= 0;
      in_frame <= 0; ackph <= 0; seen_rise <= 0; bitc <= 0; sh <= 0; hi_cnt <= 0;
    end else if (scl && scl_p && sda_p && !sda) begin
      starts <= starts + 1; in_frame <= 1; bitc <= 0; nb <= 0; ackph <= 0; seen_rise <= 0;
    end else if (scl && scl_p && !sda_p && sda) begin
      stops <= stops + 1; in_frame <= 0; pull <= 0;
    end else if (in_frame) begin
      if (scl && !scl_p) begin
        hi_cnt <= 1; seen_rise <= 1;
        if (bitc < 8) begin sh <= {sh[6:0], sda}; bitc <= bitc + 1; end
      end else if (scl) begin
        hi_cnt <= hi_cnt + 1;
      end
      if (!scl && scl_p) begin
        if (seen_rise && hi_cnt != hi_exp) bad_w <= bad_w + 1;
        if (bitc == 8 && !ackph) begin
          if (nb < 4) rx[nb] <= sh;
          pull  <= (nb != int'(nack_at));
          ackph <= 1;
        end else if (ackph) begin
          pull <= 0; ackph <= 0; bitc <= 0; nb <= nb + 1;
        end
      end
    end
    scl_p <= scl;
    sda_p <= sda;
  end
endmodule

module i2c_crc_writer_bench;
  localparam int DIV = 2;

  logic clk = 0, rst_n = 0, start = 0, clr = 1;
  logic [6:0] addr = 0;
  logic [7:0] regi = 0, dat = 0;
  logic [2:0] nack_at = 3'd4;
  int nvec = 0, nfail = 0;

  always #10 clk = ~clk;

  logic busy_a, done_a, nerr_a, scl_a, sdad_a, pull_a;
  logic busy_b, done_b, nerr_b, scl_b, sdad_b, pull_b;
  logic [1:0] nidx_a, nidx_b;
  logic sda_a, sda_b;
  logic [3:0][7:0] rx_a, rx_b;
  int nb_a, st_a, sp_a, bw_a, nb_b, st_b, sp_b, bw_b;

  assign sda_a = !(sdad_a || pull_a);
  assign sda_b = !(sdad_b || pull_b);

  i2c_crc_writer #(.CLK_DIV(DIV), .CRC_ADDR_SHIFTED(1'b1)) u_i2c_crc_writer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tgt_addr_i(addr),
    .reg_addr_i(regi), .data_i(dat), .busy_o(busy_a), .done_o(done_a),
    .nack_err_o(nerr_a), .nack_idx_o(nidx_a), .scl_drive_o(scl_a),
    .sda_drive_o(sdad_a), .sda_i(sda_a));

  i2c_crc_writer #(.CLK_DIV(DIV), .CRC_ADDR_SHIFTED(1'b0)) u_i2c_crc_writer_raw (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tgt_addr_i(addr),
    .reg_addr_i(regi), .data_i(dat), .busy_o(busy_b), .done_o(done_b),
    .nack_err_o(nerr_b), .nack_idx_o(nidx_b), .scl_drive_o(scl_b),
    .sda_drive_o(sdad_b), .sda_i(sda_b));

  i2c_crc_tgt u_tgt_a (.clk(clk), .clr(clr), .scl(!scl_a), .sda(sda_a), .nack_at(nack_at),
    .hi_exp(2*DIV), .pull(pull_a), .rx(rx_a), .nb(nb_a), .starts(st_a), .stops(sp_a), .bad_w(bw_a));
  i2c_crc_tgt u_tgt_b (.clk(clk), .clr(clr), .scl(!scl_b), .sda(sda_b), .nack_at(nack_at),
    .hi_exp(2*DIV), .pull(pull_b), .rx(rx_b), .nb(nb_b), .starts(st_b), .stops(sp_b), .bad_w(bw_b));

  function automatic logic [7:0] ref_crc(input logic [7:0] b0, b1, b2);
    logic [31:0] rem;
    rem = {b0, b1, b2, 8'h00};
    for (int i = 31; i >= 8; i--)
      if (rem[i]) rem = rem ^ (32'h107 << (i - 8));
    return rem[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  // na: byte index to refuse (4 = none); mid: issue a stray start mid-frame
  task automatic run_frame(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                           input logic [2:0] na, input bit mid);
    logic [7:0] c_a, c_b;
    int waited;
    bit got;
    @(negedge clk); clr = 1; nack_at = na;
    @(negedge clk); clr = 0;
    addr = a; regi = r; dat = d; start = 1;
    @(negedge clk); start = 0;
    chk(nerr_a == 0, "R9 nack_err cleared by start", nerr_a, 0);
    if (mid) begin
      repeat (60) @(negedge clk);
      addr = ~a; regi = ~r; dat = ~d; start = 1;
      @(negedge clk); start = 0;
    end
    waited = 0; got = 0;
    while (!got && waited < 4000) begin
      @(negedge clk); waited++;
      if (done_a) got = 1;
    end
    chk(got, "R7 done seen", int'(got), 1);
    chk(busy_a == 0 && done_b == 1, "R7 busy low and both done", {busy_a, done_b}, 1);
    @(negedge clk);
    chk(done_a == 0, "R7 done single cycle", done_a, 0);
    chk(st_a == 1 && sp_a == 1, "R6 one START one STOP", st_a * 16 + sp_a, 17);
    chk(bw_a == 0, "R8 SCL high width", bw_a, 0);
    c_a = ref_crc({a, 1'b0}, r, d);
    c_b = ref_crc({1'b0, a}, r, d);
    if (na > 3) begin
      chk(nb_a == 4, "R2 byte count", nb_a, 4);
      chk(rx_a[0] == {a, 1'b0}, "R2 address byte", rx_a[0], {a, 1'b0});
      chk(rx_a[1] == r && rx_a[2] == d, "R2 register/data bytes", {rx_a[1], rx_a[2]}, {r, d});
      chk(rx_a[3] == c_a, "R3 crc shifted address", rx_a[3], c_a);
      chk(rx_b[3] == c_b, "R3 crc raw address", rx_b[3], c_b);
      chk(nerr_a == 0 && nerr_b == 0, "R4 acked write no error", {nerr_a, nerr_b}, 0);
    end else begin
      chk(nerr_a == 1 && nerr_b == 1, "R4 refusal detected", {nerr_a, nerr_b}, 3);
      chk(nidx_a == na[1:0], "R5 failing byte index", nidx_a, na);
      chk(nb_a == int'(na) + 1, "R5 no bytes after refusal", nb_a, na + 1);
      chk(sp_a == 1, "R5 STOP after refusal", sp_a, 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R7 watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_a == 0 && done_a == 0 && nerr_a == 0, "R1 reset outputs", {busy_a, done_a, nerr_a}, 0);
    chk(scl_a == 0 && sdad_a == 0, "R1 lines released", {scl_a, sdad_a}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(busy_a == 0 && scl_a == 0 && sdad_a == 0, "R1 idle after reset", {busy_a, scl_a, sdad_a}, 0);

    run_frame(7'h08, 8'h0B, 8'h19, 3'd4, 0);
    chk(rx_a[0] == 8'h10, "R2 address byte for 0x08", rx_a[0], 8'h10);

    for (int i = 0; i < 256; i++)
      run_frame(7'((i * 37 + 8) & 8'h7f), 8'((i * 11) ^ 8'h5a), 8'(i), 3'd4, 0);

    for (int k = 0; k < 4; k++) begin
      run_frame(7'h2c + 7'(k), 8'h40 + 8'(k), 8'hc3 ^ 8'(k), 3'(k), 0);
      run_frame(7'h13, 8'h77, 8'(k), 3'd4, 0);  // R9: next good write clears error
    end

    run_frame(7'h55, 8'h81, 8'h3e, 3'd4, 1);     // R7: stray start ignored
    repeat (5) @(negedge clk);
    chk(busy_a == 0, "R7 stray start not queued", busy_a, 0);

    summary();
    $finish;
  end
endmodule